// File: doc/BRIEF.md
# Idle and Power-Down Mode Controller

This block sequences the low-power states of a small microcontroller core. Software writes two control bits: a doze bit (`mode_wdata[0]`) and a sleep bit (`mode_wdata[1]`). Doze stops only the CPU clock. The peripheral clocks keep running, so timers, the serial port and interrupt logic stay active. Sleep drops the oscillator enable, so every clock stops. The write that enters sleep is the last thing the CPU does.

The two states leave in different ways. Doze ends on an enabled pending interrupt, which also clears the doze bit, or on a hardware reset request. Sleep ends only on a hardware reset request. The controller does not touch RAM contents. A reset request fires a one-cycle register-reset strobe, which clears the control bits and the other special registers but leaves RAM alone. When a reset request arrives in doze, the CPU clock runs again for a grace window of two machine cycles before the strobe. RAM writes are blocked during that window and port writes are not. When a reset request arrives in sleep, the oscillator restarts and settles for a fixed count before the strobe.

States:
- ST_RUN: normal operation.
- ST_DOZE: CPU clock stopped.
- ST_SLEEP: oscillator off.
- ST_GRACE: reset arrived in doze; the CPU runs with RAM writes blocked.
- ST_WARM: oscillator settling after sleep.
- ST_STROBE: the one-cycle register reset.

Transitions:
- RUN→STROBE on a reset request.
- RUN→SLEEP on a write with bit 1 set.
- RUN→DOZE on a write with only bit 0 set.
- DOZE→GRACE on a reset request.
- DOZE→RUN on an interrupt.
- SLEEP→WARM on a reset request.
- GRACE→STROBE when the grace window ends.
- WARM→STROBE when the settle time ends.
- STROBE→RUN always.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After `rst_n` is released, the controller is in RUN. `cpu_clk_en`, `periph_clk_en` and `osc_en` are 1, `sfr_rst` and `ram_wr_block` are 0, and `mode_bits` is 0.
- R2: In RUN, a write with `mode_wdata` = 2'b01 enters DOZE on the next cycle. There `cpu_clk_en` is 0, `periph_clk_en` and `osc_en` are 1, and `mode_bits[0]` reads 1.
- R3: In RUN, a write with `mode_wdata[1]` = 1 enters SLEEP, where all three enables are 0. This holds even when bit 0 is also set, because sleep takes priority. `mode_bits` holds the written value.
- R4: In DOZE, `irq_pending` without a reset request returns to RUN on the next cycle and clears `mode_bits[0]`.
- R5: In SLEEP, `irq_pending` has no effect: the enables stay 0 and `mode_bits` is unchanged.
- R6: A reset request in SLEEP turns on only `osc_en` for SETTLE_CLKS cycles, then enters STROBE.
- R7: A reset request in DOZE turns on `cpu_clk_en`, `periph_clk_en` and `ram_wr_block` for 2×MACH_CYC_CLKS cycles, then enters STROBE.
- R8: STROBE lasts exactly one cycle. In it `sfr_rst` = 1, `ram_wr_block` = 1 and `osc_en` = 1, while the CPU and peripheral clocks are off. The next cycle is RUN with `mode_bits` = 0.
- R9: `mode_wr` outside RUN changes neither `mode_bits` nor the state.
- R10: A reset request has priority over a write in RUN and over an interrupt in DOZE. In RUN it goes straight to STROBE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| hw_rst_req | input | 1 | Hardware reset request, active high |
| irq_pending | input | 1 | An enabled interrupt is pending |
| mode_wr | input | 1 | Write strobe for the control bits |
| mode_wdata | input | 2 | Bit 0 = doze, bit 1 = sleep |
| mode_bits | output | 2 | Current control bit values |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| sfr_rst | output | 1 | One-cycle special register reset strobe |
| ram_wr_block | output | 1 | Blocks internal RAM writes |

## Verification
On every cycle the assertions check these relations:
- An oscillator that is off implies that both clock enables are off.
- Sleep persists until a reset request.
- Doze plus an interrupt wakes the CPU with bit 0 cleared.
- The strobe is a single cycle followed by cleared bits.
- RAM writes are blocked only while the CPU is in the grace window or the strobe.

The exact lengths of the grace and settle windows, the priority of sleep over doze, and the ignoring of writes outside RUN can only be shown by the bench's scenarios. The bench compares every output each cycle with a reference model.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_DOZE   = 3'd1,
        ST_SLEEP  = 3'd2,
        ST_GRACE  = 3'd3,
        ST_WARM   = 3'd4,
        ST_STROBE = 3'd5
    } pwr_state_e;

    localparam int DOZE_BIT  = 0;
    localparam int SLEEP_BIT = 1;
endpackage

// File: rtl/pwr_wait_timer.sv
module pwr_wait_timer #(
    parameter int MAX_CLKS = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run,
    input  logic [$clog2(MAX_CLKS+1)-1:0] limit,
    output logic                        expire
);
    localparam int CW = $clog2(MAX_CLKS + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (!expire)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wdata,
    input  logic       clr_doze,
    input  logic       clr_all,
    output logic [1:0] bits_q
);
    import pwr_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bits_q <= '0;
        else if (clr_all)
            bits_q <= '0;
        else if (wr_en)
            bits_q <= wdata;
        else if (clr_doze)
            bits_q[DOZE_BIT] <= 1'b0;
    end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_rst_req,
    input  logic       irq_pending,
    input  logic       mode_wr,
    input  logic [1:0] mode_wdata,
    input  logic       wait_done,
    output pwr_state_e state_q,
    output logic       accept_wr,
    output logic       wake_irq,
    output logic       cpu_clk_en,
    output logic       periph_clk_en,
    output logic       osc_en,
    output logic       sfr_rst,
    output logic       ram_wr_block
);
    pwr_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        accept_wr = 1'b0;
        wake_irq  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (hw_rst_req) begin
                    state_d = ST_STROBE;
                end else if (mode_wr) begin
                    accept_wr = 1'b1;
                    if (mode_wdata[SLEEP_BIT])     state_d = ST_SLEEP;
                    else if (mode_wdata[DOZE_BIT]) state_d = ST_DOZE;
                end
            end
            ST_DOZE: begin
                if (hw_rst_req) begin
                    state_d = ST_GRACE;
                end else if (irq_pending) begin
                    state_d  = ST_RUN;
                    wake_irq = 1'b1;
                end
            end
            ST_SLEEP:  if (hw_rst_req) state_d = ST_WARM;
            ST_GRACE:  if (wait_done)  state_d = ST_STROBE;
            ST_WARM:   if (wait_done)  state_d = ST_STROBE;
            ST_STROBE: state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    always_comb begin
        cpu_clk_en    = 1'b0;
        periph_clk_en = 1'b0;
        osc_en        = 1'b1;
        sfr_rst       = 1'b0;
        ram_wr_block  = 1'b0;
        unique case (state_q)
            ST_RUN:    begin cpu_clk_en = 1'b1; periph_clk_en = 1'b1; end
            ST_DOZE:   periph_clk_en = 1'b1;
            ST_SLEEP:  osc_en = 1'b0;
            ST_GRACE:  begin cpu_clk_en = 1'b1; periph_clk_en = 1'b1; ram_wr_block = 1'b1; end
            ST_WARM:   ;
            ST_STROBE: begin sfr_rst = 1'b1; ram_wr_block = 1'b1; end
            default:   ;
        endcase
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
    parameter int MACH_CYC_CLKS = 12,
    parameter int SETTLE_CLKS   = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_rst_req,
    input  logic       irq_pending,
    input  logic       mode_wr,
    input  logic [1:0] mode_wdata,
    output logic [1:0] mode_bits,
    output logic       cpu_clk_en,
    output logic       periph_clk_en,
    output logic       osc_en,
    output logic       sfr_rst,
    output logic       ram_wr_block
);
    import pwr_pkg::*;

    localparam int GRACE_CLKS = 2 * MACH_CYC_CLKS;
    localparam int MAX_CLKS   = (GRACE_CLKS > SETTLE_CLKS) ? GRACE_CLKS : SETTLE_CLKS;
    localparam int CW         = $clog2(MAX_CLKS + 1);

    pwr_state_e    state_q;
    logic          accept_wr, wake_irq, wait_done, wait_run;
    logic [CW-1:0] wait_limit;

    assign wait_run   = (state_q == ST_GRACE) || (state_q == ST_WARM);
    assign wait_limit = (state_q == ST_WARM) ? CW'(SETTLE_CLKS) : CW'(GRACE_CLKS);

    pwr_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .hw_rst_req   (hw_rst_req),
        .irq_pending  (irq_pending),
        .mode_wr      (mode_wr),
        .mode_wdata   (mode_wdata),
        .wait_done    (wait_done),
        .state_q      (state_q),
        .accept_wr    (accept_wr),
        .wake_irq     (wake_irq),
        .cpu_clk_en   (cpu_clk_en),
        .periph_clk_en(periph_clk_en),
        .osc_en       (osc_en),
        .sfr_rst      (sfr_rst),
        .ram_wr_block (ram_wr_block)
    );

    pwr_wait_timer #(.MAX_CLKS(MAX_CLKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (wait_run),
        .limit (wait_limit),
        .expire(wait_done)
    );

    pwr_mode_reg u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept_wr),
        .wdata   (mode_wdata),
        .clr_doze(wake_irq),
        .clr_all (sfr_rst),
        .bits_q  (mode_bits)
    );
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hw_rst_req,
    input logic       irq_pending,
    input logic [1:0] mode_bits,
    input logic       cpu_clk_en,
    input logic       periph_clk_en,
    input logic       osc_en,
    input logic       sfr_rst,
    input logic       ram_wr_block
);
    // R3
    sleep_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!cpu_clk_en && !periph_clk_en));

    // R5
    sleep_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !hw_rst_req) |=> (!osc_en && $stable(mode_bits)));

    // R4
    doze_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && periph_clk_en && irq_pending && !hw_rst_req)
            |=> (cpu_clk_en && !mode_bits[0] && !ram_wr_block));

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_rst |=> (!sfr_rst && mode_bits == 2'b00 && cpu_clk_en));

    // R7
    block_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_block |-> (sfr_rst || (cpu_clk_en && periph_clk_en)));

    // R10
    doze_reset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && periph_clk_en && hw_rst_req) |=> ram_wr_block);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_rst_req   (hw_rst_req),
    .irq_pending  (irq_pending),
    .mode_bits    (mode_bits),
    .cpu_clk_en   (cpu_clk_en),
    .periph_clk_en(periph_clk_en),
    .osc_en       (osc_en),
    .sfr_rst      (sfr_rst),
    .ram_wr_block (ram_wr_block)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
    localparam int MC = 12;
    localparam int ST = 64;
    localparam int GR = 2 * MC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_rst_req = 1'b0, irq_pending = 1'b0, mode_wr = 1'b0;
    logic [1:0] mode_wdata = 2'b00;
    logic [1:0] mode_bits;
    logic       cpu_clk_en, periph_clk_en, osc_en, sfr_rst, ram_wr_block;

    int checks = 0, errors = 0;
    int ms = 0, mcnt = 0;
    logic [1:0] mbits = 2'b00;
    bit done = 0;

    always #5 clk = ~clk;

    pwr_mode_ctrl #(.MACH_CYC_CLKS(MC), .SETTLE_CLKS(ST)) u0 (
        .clk(clk), .rst_n(rst_n), .hw_rst_req(hw_rst_req), .irq_pending(irq_pending),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .mode_bits(mode_bits),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
        .sfr_rst(sfr_rst), .ram_wr_block(ram_wr_block)
    );

    // model states: 0 run, 1 doze, 2 sleep, 3 grace, 4 warm, 5 strobe
    function automatic logic [4:0] exp_out(int s);
        logic cpu, per, osc, sr, blk;
        cpu = (s == 0) || (s == 3);
        per = (s == 0) || (s == 1) || (s == 3);
        osc = (s != 2);
        sr  = (s == 5);
        blk = (s == 3) || (s == 5);
        return {cpu, per, osc, sr, blk};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mcnt = 0; mbits = 2'b00;
        end else begin
            case (ms)
                0: if (hw_rst_req) ms = 5;
                   else if (mode_wr) begin
                       mbits = mode_wdata;
                       if (mode_wdata[1]) ms = 2; else if (mode_wdata[0]) ms = 1;
                   end
                1: if (hw_rst_req) begin ms = 3; mcnt = 0; end
                   else if (irq_pending) begin ms = 0; mbits[0] = 1'b0; end
                2: if (hw_rst_req) begin ms = 4; mcnt = 0; end
                3: if (mcnt == GR - 1) ms = 5; else mcnt++;
                4: if (mcnt == ST - 1) ms = 5; else mcnt++;
                default: begin ms = 0; mbits = 2'b00; end
            endcase
        end
    end

    task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s enables act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic chk_bits(string tag, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s mode_bits act=%b exp=%b", tag, act, exp);
        end
    endtask

    function automatic string tag_of(int s);
        case (s)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R7";
            4: return "R6";
            default: return "R8";
        endcase
    endfunction

    // full compare every cycle against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(tag_of(ms), {cpu_clk_en, periph_clk_en, osc_en, sfr_rst, ram_wr_block}, exp_out(ms));
            chk_bits("R9", mode_bits, mbits);
        end
    end

    task automatic cyc(bit h, bit i, bit w, logic [1:0] d);
        hw_rst_req = h; irq_pending = i; mode_wr = w; mode_wdata = d;
        @(negedge clk);
    endtask

    task automatic run_n(int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 2'b00);
    endtask

    int cnt_len;

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {cpu_clk_en, periph_clk_en, osc_en, sfr_rst, ram_wr_block}, 5'b11100);
        chk_bits("R1", mode_bits, 2'b00);

        // R2 doze, then R9 write ignored, R4 irq wake
        cyc(0, 0, 1, 2'b01);
        chk("R2", {cpu_clk_en, periph_clk_en, osc_en, sfr_rst, ram_wr_block}, 5'b01100);
        chk_bits("R2", mode_bits, 2'b01);
        cyc(0, 0, 1, 2'b10);
        chk_bits("R9", mode_bits, 2'b01);
        chk("R9", {cpu_clk_en, periph_clk_en, osc_en, sfr_rst, ram_wr_block}, 5'b01100);
        cyc(0, 1, 0, 2'b00);
        chk("R4", {cpu_clk_en, periph_clk_en, osc_en, sfr_rst, ram_wr_block}, 5'b11100);
        chk_bits("R4", mode_bits, 2'b00);

        // R3 both bits -> sleep, R5 irq ignored
        cyc(0, 0, 1, 2'b11);
        chk("R3", {cpu_clk_en, periph_clk_en, osc_en, sfr_rst, ram_wr_block}, 5'b00000);
        chk_bits("R3", mode_bits, 2'b11);
        cyc(0, 1, 0, 2'b00);
        cyc(0, 1, 0, 2'b00);
        chk("R5", {cpu_clk_en, periph_clk_en, osc_en, sfr_rst, ram_wr_block}, 5'b00000);
        chk_bits("R5", mode_bits, 2'b11);

        // R6 settle window length
        cyc(1, 0, 0, 2'b00);
        cnt_len = 0;
        while (osc_en && !cpu_clk_en && !sfr_rst && cnt_len < 1000) begin
            cnt_len++; cyc(0, 0, 0, 2'b00);
        end
        checks++;
        if (cnt_len != ST) begin errors++; $display("FAIL R6 settle act=%0d exp=%0d", cnt_len, ST); end
        chk("R8", {cpu_clk_en, periph_clk_en, osc_en, sfr_rst, ram_wr_block}, 5'b00111);
        cyc(0, 0, 0, 2'b00);
        chk_bits("R8", mode_bits, 2'b00);

        // R7 grace window, R10 reset beats irq
        cyc(0, 0, 1, 2'b01);
        cyc(1, 1, 0, 2'b00);
        cnt_len = 0;
        while (ram_wr_block && cpu_clk_en && cnt_len < 1000) begin
            cnt_len++; cyc(0, 0, 0, 2'b00);
        end
        checks++;
        if (cnt_len != GR) begin errors++; $display("FAIL R7 grace act=%0d exp=%0d", cnt_len, GR); end
        chk("R10", {cpu_clk_en, periph_clk_en, osc_en, sfr_rst, ram_wr_block}, 5'b00111);

        // R10 reset beats write in run
        run_n(2);
        cyc(1, 0, 1, 2'b10);
        chk("R10", {cpu_clk_en, periph_clk_en, osc_en, sfr_rst, ram_wr_block}, 5'b00111);
        chk_bits("R10", mode_bits, 2'b00);
        run_n(2);

        // constrained random against the model
        for (int k = 0; k < 6000; k++) begin
            cyc(($urandom % 40) == 0, ($urandom % 8) == 0, ($urandom % 6) == 0,
                2'($urandom % 4));
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule